// File: doc/BRIEF.md
# Serial Link Rate and Status Controller

This block is the control and status front end of a byte-oriented serial link engine. A CPU register write loads an 8-bit rate word. Its upper three bits select a power-of-two prescaler exponent, and its lower five bits set an inter-bit gap count. From these the block produces a one-cycle prescaled sample tick and a one-cycle "next bit allowed" strobe for the engine. The top exponent code stops the engine's timebase entirely.

A CPU register read returns an 8-bit status word. The three low bits are sticky interrupt causes. Each one latches on the rising edge of an engine event and clears on a read. The five high bits are live copies of engine state lines. A single interrupt line is the OR of the three sticky bits.

The engine shares the CPU clock. With the nominal 6 MHz clock, software should choose the exponent and gap so that successive bits stay at least 2 µs apart.

Top module: `link_rate_status`

## Requirements
- R1: After reset the rate word is 0 (exponent 0, gap 0). All sticky flags and `irq` are 0, and `sample_tick` is high in every cycle.
- R2: For an exponent n from 0 to 6 in `wr_data[7:5]`, `sample_tick` is a pulse with a period of 2^n cycles. Count the cycle after the write edge as cycle 0. The tick is high in cycle k exactly when k mod 2^n equals 2^n-1.
- R3: Exponent code 7 halts the block: no `sample_tick` and no `bit_allow`. A pending gap count is frozen and resumes after a non-halt rate is written.
- R4: A `bit_start` pulse loads the gap g from `wr_data[4:0]`. `bit_allow` is then high for one cycle, coinciding with the (g+1)-th `sample_tick` after the `bit_start` cycle, and it is never high at any other time. A tick in the `bit_start` cycle itself is not counted.
- R5: Status bit 0 latches on a rising edge of `evt_rx_byte`, bit 1 on a rising edge of `evt_tx_space`, and bit 2 on a rising edge of `evt_tx_fault`. Each bit is visible in `rd_data` from the next cycle.
- R6: A cycle with `rd_en` high returns the current flags on `rd_data`, and clears bits 2:0 from the next cycle. If a rising edge occurs in that same cycle, its bit stays set.
- R7: An event input that stays high does not set its flag again after a clear.
- R8: `rd_data` bits 7:3 follow `st_rx_active`, `st_rx_full`, `st_tx_room`, `st_fault` and `st_tx_active` respectively, in the same cycle and with no latching.
- R9: `irq` is high exactly when any of `rd_data[2:0]` is high.
- R10: Every rate write restarts the prescaler phase, so the first tick after a write falls in cycle 2^n-1, whatever the earlier phase was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared CPU and engine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Rate word write strobe |
| wr_data | input | 8 | Rate word: [7:5] exponent, [4:0] gap |
| rd_en | input | 1 | Status read strobe (clears sticky flags) |
| rd_data | output | 8 | Status word |
| irq | output | 1 | OR of the sticky flags |
| evt_rx_byte | input | 1 | Engine event: byte received |
| evt_tx_space | input | 1 | Engine event: byte may be sent |
| evt_tx_fault | input | 1 | Engine event: transmission error |
| st_rx_active | input | 1 | Live: reception in progress |
| st_rx_full | input | 1 | Live: received byte waiting |
| st_tx_room | input | 1 | Live: engine can accept a byte |
| st_fault | input | 1 | Live: error occurred |
| st_tx_active | input | 1 | Live: byte being sent |
| bit_start | input | 1 | Engine pulse: a bit has just started |
| sample_tick | output | 1 | Prescaled sample tick |
| bit_allow | output | 1 | Strobe: next bit may start |

## Verification
The bench measures the tick phase after every exponent. It also rewrites the rate in mid-count: a prescaler that kept its old phase, or that decoded 2^n off by one, puts the first tick in the wrong cycle. It parks a gap count under the halt code and then releases it. A design that kept counting, or one that reloaded on the write, places `bit_allow` too early or too late. It drives events that coincide with reads and levels that are held across a clear, so a design that lets the read win, or that triggers on level instead of edge, shows a wrong flag.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

   // status word layout, most significant bit first
   typedef struct packed {
      logic tx_active;
      logic fault;
      logic tx_room;
      logic rx_full;
      logic rx_active;
      logic fault_irq;
      logic tx_irq;
      logic rx_irq;
   } lrs_status_t;

   localparam int unsigned LRS_N_STICKY = 3;
   localparam int unsigned LRS_N_LIVE   = 5;

endpackage

// File: rtl/lrs_prescaler.sv
module lrs_prescaler #(
   parameter int unsigned EXP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [EXP_W-1:0] exp_i,
   output logic             halt_o,
   output logic             tick_o
);
   localparam int unsigned HALT_CODE = (1 << EXP_W) - 1;
   localparam int unsigned CNT_W     = HALT_CODE - 1;

   if (EXP_W < 2) begin : g_bad_exp
      $error("lrs_prescaler: EXP_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   // mask holds n low ones for exponent n
   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign mask[i] = (int'(exp_i) > i);
   end

   assign halt_o = (exp_i == EXP_W'(HALT_CODE));
   assign tick_o = !halt_o && ((cnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         cnt <= '0;
      end else if (!halt_o) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/lrs_gap_timer.sv
module lrs_gap_timer #(
   parameter int unsigned GAP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GAP_W-1:0] gap_i,
   input  logic             tick_i,
   input  logic             bit_start_i,
   output logic             bit_allow_o
);
   if (GAP_W < 1) begin : g_bad_gap
      $error("lrs_gap_timer: GAP_W must be at least 1");
   end

   logic             armed;
   logic [GAP_W-1:0] left;

   // a fresh bit start takes priority over a tick in the same cycle
   assign bit_allow_o = armed && tick_i && !bit_start_i && (left == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         left  <= '0;
      end else if (bit_start_i) begin
         armed <= 1'b1;
         left  <= gap_i;
      end else if (armed && tick_i) begin
         if (left == '0) begin
            armed <= 1'b0;
         end else begin
            left <= left - GAP_W'(1);
         end
      end
   end

endmodule

// File: rtl/lrs_status.sv
module lrs_status
   import lrs_pkg::*;
#(
   parameter int unsigned N_STICKY = LRS_N_STICKY,
   parameter int unsigned N_LIVE   = LRS_N_LIVE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic [N_STICKY-1:0] evt_i,
   input  logic [N_LIVE-1:0]   live_i,
   output lrs_status_t         word_o,
   output logic                irq_o
);
   localparam int unsigned WORD_W = N_STICKY + N_LIVE;

   if (WORD_W != $bits(lrs_status_t)) begin : g_bad_word
      $error("lrs_status: sticky plus live bits must fill the status word");
   end

   logic [N_STICKY-1:0] evt_prev;
   logic [N_STICKY-1:0] flags;

   for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
      logic rise;
      assign rise = evt_i[i] && !evt_prev[i];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            evt_prev[i] <= 1'b0;
            flags[i]    <= 1'b0;
         end else begin
            evt_prev[i] <= evt_i[i];
            flags[i]    <= (flags[i] && !rd_en) || rise;
         end
      end
   end

   assign word_o = lrs_status_t'({live_i, flags});
   assign irq_o  = |flags;

endmodule

// File: rtl/link_rate_status.sv
module link_rate_status
   import lrs_pkg::*;
#(
   parameter int unsigned EXP_W = 3,
   parameter int unsigned GAP_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   output logic       irq,
   input  logic       evt_rx_byte,
   input  logic       evt_tx_space,
   input  logic       evt_tx_fault,
   input  logic       st_rx_active,
   input  logic       st_rx_full,
   input  logic       st_tx_room,
   input  logic       st_fault,
   input  logic       st_tx_active,
   input  logic       bit_start,
   output logic       sample_tick,
   output logic       bit_allow
);
   localparam int unsigned RATE_W = EXP_W + GAP_W;

   if (RATE_W != 8) begin : g_bad_rate
      $error("link_rate_status: exponent and gap fields must fill 8 bits");
   end

   logic [RATE_W-1:0] rate_q;
   logic [EXP_W-1:0]  rate_exp;
   logic [GAP_W-1:0]  rate_gap;
   logic              halted;
   lrs_status_t       word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= '0;
      end else if (wr_en) begin
         rate_q <= wr_data;
      end
   end

   assign rate_exp = rate_q[RATE_W-1 -: EXP_W];
   assign rate_gap = rate_q[GAP_W-1:0];

   lrs_prescaler #(.EXP_W(EXP_W)) i_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_en),
      .exp_i   (rate_exp),
      .halt_o  (halted),
      .tick_o  (sample_tick)
   );

   lrs_gap_timer #(.GAP_W(GAP_W)) i_gap (
      .clk         (clk),
      .rst_n       (rst_n),
      .gap_i       (rate_gap),
      .tick_i      (sample_tick),
      .bit_start_i (bit_start),
      .bit_allow_o (bit_allow)
   );

   lrs_status i_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .evt_i  ({evt_tx_fault, evt_tx_space, evt_rx_byte}),
      .live_i ({st_tx_active, st_fault, st_tx_room, st_rx_full, st_rx_active}),
      .word_o (word),
      .irq_o  (irq)
   );

   assign rd_data = word;

endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
   parameter int unsigned EXP_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [EXP_W-1:0] rate_exp,
   input logic             sample_tick,
   input logic             bit_allow,
   input logic             rd_en,
   input logic             evt_rx_byte,
   input logic [7:0]       rd_data,
   input logic             irq
);
   localparam logic [EXP_W-1:0] HALT = '1;

   a_r3_halt_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_exp == HALT) |-> !sample_tick);

   a_r3_halt_no_allow: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_exp == HALT) |-> !bit_allow);

   a_r4_allow_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      bit_allow |-> sample_tick);

   a_r5_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_rx_byte) |=> rd_data[0]);

   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !evt_rx_byte) |=> !rd_data[0]);

   a_r9_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (|rd_data[2:0]));

endmodule

bind link_rate_status lrs_checker #(.EXP_W(EXP_W)) i_lrs_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .rate_exp    (rate_exp),
   .sample_tick (sample_tick),
   .bit_allow   (bit_allow),
   .rd_en       (rd_en),
   .evt_rx_byte (evt_rx_byte),
   .rd_data     (rd_data),
   .irq         (irq)
);

// File: tb/test_link_rate_status.sv
`timescale 1ns/1ps
module test_link_rate_status;
   logic       clk = 1'b0;
   logic       rst_n, wr_en, rd_en, irq, bit_start, sample_tick, bit_allow;
   logic [7:0] wr_data, rd_data;
   logic [2:0] evt;
   logic [4:0] live;
   int         errs = 0, checks = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   link_rate_status i_link_rate_status (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
      .evt_rx_byte(evt[0]), .evt_tx_space(evt[1]), .evt_tx_fault(evt[2]),
      .st_rx_active(live[0]), .st_rx_full(live[1]), .st_tx_room(live[2]),
      .st_fault(live[3]), .st_tx_active(live[4]),
      .bit_start(bit_start), .sample_tick(sample_tick), .bit_allow(bit_allow)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_tick(input int n, input int k);
      int p = 1 << n;
      return (k % p) == (p - 1);
   endfunction

   task automatic wr(input logic [7:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pulse_start();
      bit_start = 1'b1;
      @(negedge clk); bit_start = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errs++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [2:0] mflags, mprev;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
      evt = '0; live = '0; bit_start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(rd_data == 8'h00, "R1 status", rd_data, 0);
      chk(irq == 1'b0, "R1 irq", irq, 0);
      chk(sample_tick == 1'b1, "R1 tick every cycle", sample_tick, 1);
      chk(bit_allow == 1'b0, "R1 allow", bit_allow, 0);

      // R2 tick period for each exponent
      for (int n = 0; n <= 6; n++) begin
         wr({3'(n), 5'd0});
         for (int k = 0; k < 3 * (1 << n); k++) begin
            #1 chk(sample_tick == exp_tick(n, k), "R2 tick phase", sample_tick, exp_tick(n, k));
            @(negedge clk);
         end
      end

      // R10 rewrite mid count restarts phase
      wr({3'd2, 5'd0});
      @(negedge clk); @(negedge clk);
      wr({3'd2, 5'd0});
      for (int k = 0; k < 8; k++) begin
         #1 chk(sample_tick == exp_tick(2, k), "R10 restart phase", sample_tick, exp_tick(2, k));
         @(negedge clk);
      end

      // R3 halt freezes everything, gap resumes afterwards
      wr({3'd7, 5'd4});
      pulse_start();
      for (int k = 0; k < 100; k++) begin
         #1 chk(sample_tick == 1'b0, "R3 halt tick", sample_tick, 0);
         chk(bit_allow == 1'b0, "R3 halt allow", bit_allow, 0);
         @(negedge clk);
      end
      wr({3'd0, 5'd4});
      for (int k = 0; k < 8; k++) begin
         #1 chk(bit_allow == (k == 4), "R3 frozen gap resumes", bit_allow, int'(k == 4));
         @(negedge clk);
      end

      // R4 gap timing
      for (int n = 0; n <= 2; n++) begin
         foreach (wr_data[i]) begin end
         for (int gi = 0; gi < 4; gi++) begin
            int g, ticks;
            bit seen;
            g = (gi == 0) ? 0 : (gi == 1) ? 1 : (gi == 2) ? 5 : 31;
            wr({3'(n), 5'(g)});
            pulse_start();
            ticks = 0; seen = 1'b0;
            for (int k = 0; k < (g + 3) * (1 << n) + 4; k++) begin
               bit e;
               #1 e = sample_tick && (ticks == g) && !seen;
               chk(bit_allow == e, "R4 gap strobe", bit_allow, e);
               if (sample_tick) ticks++;
               if (e) seen = 1'b1;
               @(negedge clk);
            end
            chk(seen, "R4 strobe issued", seen, 1);
         end
      end

      // R5 R6 R7 directed flag cases
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
      evt = 3'b001; @(negedge clk);
      evt = 3'b000;
      #1 chk(rd_data[2:0] == 3'b001, "R5 rx flag set", rd_data[2:0], 1);
      chk(irq == 1'b1, "R9 irq with flag", irq, 1);
      @(negedge clk);
      evt = 3'b001; rd_en = 1'b1;
      #1 chk(rd_data[2:0] == 3'b001, "R6 read returns flag", rd_data[2:0], 1);
      @(negedge clk); rd_en = 1'b0;
      #1 chk(rd_data[2:0] == 3'b001, "R6 event wins over read", rd_data[2:0], 1);
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
      #1 chk(rd_data[2:0] == 3'b000, "R7 held level no reset", rd_data[2:0], 0);
      @(negedge clk);
      #1 chk(rd_data[2:0] == 3'b000, "R7 held level stays clear", rd_data[2:0], 0);
      evt = 3'b110; @(negedge clk); evt = 3'b000;
      #1 chk(rd_data[2:0] == 3'b110, "R5 tx and fault flags", rd_data[2:0], 6);
      live = 5'b10110;
      #1 chk(rd_data[7:3] == 5'b10110, "R8 live bits", rd_data[7:3], 5'b10110);
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; live = '0;
      #1 chk(irq == 1'b0, "R9 irq after clear", irq, 0);

      // random flag and live traffic against a bench model
      mflags = 3'b000; mprev = 3'b000;
      for (int c = 0; c < 3000; c++) begin
         logic [7:0] e;
         evt   = 3'($urandom) & 3'($urandom);
         live  = 5'($urandom);
         rd_en = ($urandom % 4) == 0;
         #1 e = {live, mflags};
         chk(rd_data == e, "R5 R6 R7 R8 random status", rd_data, e);
         chk(irq == (|mflags), "R9 random irq", irq, |mflags);
         mflags = (mflags & ~{3{rd_en}}) | (evt & ~mprev);
         mprev  = evt;
         @(negedge clk);
      end

      finish_run();
   end
endmodule